// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block holds the configuration and status state of an SDRAM controller behind a two-port indirect host interface. The host first writes an internal offset into a pointer port. It then reads or writes the selected register through a data-window port. Each internal register has its own write masking. Some registers have extra behaviour: write-one-to-clear error words, a read-only status word that follows edges of the configuration bits, a power timer with forced-one bits, and an ECC error word that drives a level interrupt.

The global enable bit, the bank control words and the timing word are exported to the neighbouring address decoder and command logic. The number of bank control words is a parameter of one to four. The bank words sit at consecutive word offsets starting at 0x40. A bank offset at or beyond the configured count behaves like an unlisted offset. Read data is combinational from registered state, so a value written on one clock edge is visible on the read port right after that edge.

Top module: `sdcfg_top`

## Requirements
- R1: A write with `host_port`=0 stores the 32-bit value as the pointer. A read with `host_port`=0 returns the stored pointer. A data-window access (`host_port`=1) targets the register whose offset equals the pointer.
- R2: After reset, these values hold: pointer 0; configuration 0x00800000; status 0; refresh 0x05F00000; power timer 0x07C00000; timing word 0x00854009; both bus-error words, error address, ECC configuration and ECC error word 0; `irq_o` 0; `mem_en_o` 0.
- R3: The bus-error words at 0x00 and 0x08 are write-one-to-clear: each 1 bit written clears that bit. The error address at 0x10 stores the written value unchanged.
- R4: Configuration (0x20) stores the written value ANDed with 0xFFE00000. When bit 31 goes from 0 to 1, status bit 31 clears. When bit 31 goes from 1 to 0, status bit 31 sets. `mem_en_o` follows configuration bit 31.
- R5: When configuration bit 30 rises, status bit 30 sets. When configuration bit 30 falls, status bit 30 clears.
- R6: Writes to the status offset 0x24 leave status unchanged.
- R7: Refresh (0x30) keeps the written value ANDed with 0x3FF80000. ECC configuration (0x94) keeps it ANDed with 0x00F00000. The timing word (0x80) keeps it ANDed with 0x018FC01F, and that value is driven on `tmg_o`. A data read at 0x80 returns 0xFFFFFFFF.
- R8: The power timer (0x34) stores (written value AND 0xF8000000) OR 0x07C00000.
- R9: Bank control word i (offset 0x40+4*i, i < NBANK) stores the written value ANDed with 0xFFDEE001. It reads back and is driven on `bank_ctl_o[32*i +: 32]`.
- R10: The ECC error word (0x98) stores the written value ANDed with 0xFFF0F000. `irq_o` sets when that word goes from zero to nonzero and clears when it goes from nonzero to zero.
- R11: A data read at an unlisted offset, including a bank offset at or beyond NBANK, returns 0xFFFFFFFF. A data write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Write when 1, read when 0 |
| host_port | input | 1 | 0 = pointer port, 1 = data window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data for the selected port |
| mem_en_o | output | 1 | Global memory enable (configuration bit 31) |
| bank_ctl_o | output | 32*NBANK | Packed bank control words, bank i at bits 32*i upward |
| tmg_o | output | 32 | Stored timing word |
| irq_o | output | 1 | Registered ECC error interrupt level |

## Verification
The bench builds two instances on the same host bus. One uses the default of four banks, so every bank offset and the full export vector are reachable. The other uses two banks, so the same writes and reads at 0x48 and 0x4C meet the unlisted-offset path. This lets the bench check that the bank count alone decides whether an offset is live, and that the bank export shrinks to match.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  typedef logic [31:0] word_t;

  localparam word_t OFF_BERR_A = 32'h00;
  localparam word_t OFF_BERR_B = 32'h08;
  localparam word_t OFF_EADDR  = 32'h10;
  localparam word_t OFF_GCFG   = 32'h20;
  localparam word_t OFF_GSTAT  = 32'h24;
  localparam word_t OFF_RFSH   = 32'h30;
  localparam word_t OFF_PWR    = 32'h34;
  localparam word_t OFF_BANK0  = 32'h40;
  localparam word_t OFF_TMG    = 32'h80;
  localparam word_t OFF_ECFG   = 32'h94;
  localparam word_t OFF_EERR   = 32'h98;

  localparam word_t MSK_GCFG   = 32'hFFE00000;
  localparam word_t MSK_RFSH   = 32'h3FF80000;
  localparam word_t MSK_PWR    = 32'hF8000000;
  localparam word_t SET_PWR    = 32'h07C00000;
  localparam word_t MSK_BANK   = 32'hFFDEE001;
  localparam word_t MSK_TMG    = 32'h018FC01F;
  localparam word_t MSK_ECFG   = 32'h00F00000;
  localparam word_t MSK_EERR   = 32'hFFF0F000;

  localparam word_t RST_GCFG   = 32'h00800000;
  localparam word_t RST_RFSH   = 32'h05F00000;
  localparam word_t RST_PWR    = 32'h07C00000;
  localparam word_t RST_TMG    = 32'h00854009;
  localparam word_t ALL_ONES   = 32'hFFFFFFFF;
endpackage

// File: rtl/sdcfg_gctl.sv
module sdcfg_gctl
  import sdcfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_cfg,
  input  logic  wr_stat,
  input  word_t wdata,
  output word_t cfg_q,
  output word_t stat_q
);
  word_t nv;
  assign nv = wdata & MSK_GCFG;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= RST_GCFG;
      stat_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= nv;
      if (!cfg_q[31] && nv[31])      stat_q[31] <= 1'b0;
      else if (cfg_q[31] && !nv[31]) stat_q[31] <= 1'b1;
      if (!cfg_q[30] && nv[30])      stat_q[30] <= 1'b1;
      else if (cfg_q[30] && !nv[30]) stat_q[30] <= 1'b0;
    end
  end

  // R4
  en_rise_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !cfg_q[31] && wdata[31]) |=> (!stat_q[31] && cfg_q[31]));
  // R4
  en_fall_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && cfg_q[31] && !wdata[31]) |=> stat_q[31]);
  // R5
  b30_rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !cfg_q[30] && wdata[30]) |=> stat_q[30]);
  // R6
  stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> $stable(stat_q));
endmodule

// File: rtl/sdcfg_bank.sv
module sdcfg_bank
  import sdcfg_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  word_t             ptr,
  input  word_t             wdata,
  output logic [NBANK*32-1:0] bank_flat,
  output logic              rd_hit,
  output word_t             rd_val
);
  word_t bank_q [NBANK];

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam word_t OFF_I = OFF_BANK0 + 32'(4 * i);
    always_ff @(posedge clk) begin
      if (rst)                          bank_q[i] <= '0;
      else if (wr_data && ptr == OFF_I) bank_q[i] <= wdata & MSK_BANK;
    end
    assign bank_flat[32*i +: 32] = bank_q[i];

    // R9
    bank_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
      (bank_q[i] & ~MSK_BANK) == '0);
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_val = ALL_ONES;
    for (int k = 0; k < NBANK; k++) begin
      if (ptr == OFF_BANK0 + 32'(4 * k)) begin
        rd_hit = 1'b1;
        rd_val = bank_q[k];
      end
    end
  end
endmodule

// File: rtl/sdcfg_ecc.sv
module sdcfg_ecc
  import sdcfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_cfg,
  input  logic  wr_err,
  input  word_t wdata,
  output word_t ecfg_q,
  output word_t eerr_q,
  output logic  irq_q
);
  word_t nerr;
  assign nerr = wdata & MSK_EERR;

  always_ff @(posedge clk) begin
    if (rst) begin
      ecfg_q <= '0;
      eerr_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_cfg) ecfg_q <= wdata & MSK_ECFG;
      if (wr_err) begin
        eerr_q <= nerr;
        if (eerr_q == '0 && nerr != '0)      irq_q <= 1'b1;
        else if (eerr_q != '0 && nerr == '0) irq_q <= 1'b0;
      end
    end
  end

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(wr_err));
  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_err && (wdata & MSK_EERR) == '0) |=> !irq_q);
endmodule

// File: rtl/sdcfg_top.sv
module sdcfg_top
  import sdcfg_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_sel,
  input  logic                host_we,
  input  logic                host_port,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         host_rdata,
  output logic                mem_en_o,
  output logic [NBANK*32-1:0] bank_ctl_o,
  output logic [31:0]         tmg_o,
  output logic                irq_o
);
  word_t ptr_q, berr_a_q, berr_b_q, eaddr_q, rfsh_q, pwr_q, tmg_q;
  word_t cfg_q, stat_q, ecfg_q, eerr_q, bank_rd;
  logic  bank_hit;
  logic  wr_ptr, wr_data;

  assign wr_ptr  = host_sel && host_we && !host_port;
  assign wr_data = host_sel && host_we &&  host_port;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      berr_a_q <= '0;
      berr_b_q <= '0;
      eaddr_q  <= '0;
      rfsh_q   <= RST_RFSH;
      pwr_q    <= RST_PWR;
      tmg_q    <= RST_TMG;
    end else begin
      if (wr_ptr) ptr_q <= host_wdata;
      if (wr_data) begin
        unique case (ptr_q)
          OFF_BERR_A: berr_a_q <= berr_a_q & ~host_wdata;
          OFF_BERR_B: berr_b_q <= berr_b_q & ~host_wdata;
          OFF_EADDR:  eaddr_q  <= host_wdata;
          OFF_RFSH:   rfsh_q   <= host_wdata & MSK_RFSH;
          OFF_PWR:    pwr_q    <= (host_wdata & MSK_PWR) | SET_PWR;
          OFF_TMG:    tmg_q    <= host_wdata & MSK_TMG;
          default: ;
        endcase
      end
    end
  end

  sdcfg_gctl u_gctl (
    .clk    (clk),
    .rst    (rst),
    .wr_cfg (wr_data && ptr_q == OFF_GCFG),
    .wr_stat(wr_data && ptr_q == OFF_GSTAT),
    .wdata  (host_wdata),
    .cfg_q  (cfg_q),
    .stat_q (stat_q)
  );

  sdcfg_bank #(.NBANK(NBANK)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_data),
    .ptr      (ptr_q),
    .wdata    (host_wdata),
    .bank_flat(bank_ctl_o),
    .rd_hit   (bank_hit),
    .rd_val   (bank_rd)
  );

  sdcfg_ecc u_ecc (
    .clk   (clk),
    .rst   (rst),
    .wr_cfg(wr_data && ptr_q == OFF_ECFG),
    .wr_err(wr_data && ptr_q == OFF_EERR),
    .wdata (host_wdata),
    .ecfg_q(ecfg_q),
    .eerr_q(eerr_q),
    .irq_q (irq_o)
  );

  word_t win;
  always_comb begin
    unique case (ptr_q)
      OFF_BERR_A: win = berr_a_q;
      OFF_BERR_B: win = berr_b_q;
      OFF_EADDR:  win = eaddr_q;
      OFF_GCFG:   win = cfg_q;
      OFF_GSTAT:  win = stat_q;
      OFF_RFSH:   win = rfsh_q;
      OFF_PWR:    win = pwr_q;
      OFF_ECFG:   win = ecfg_q;
      OFF_EERR:   win = eerr_q;
      default:    win = bank_hit ? bank_rd : ALL_ONES;
    endcase
  end

  assign host_rdata = host_port ? win : ptr_q;
  assign mem_en_o   = cfg_q[31];
  assign tmg_o      = tmg_q;

  // R3
  berr_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && ptr_q == OFF_BERR_A) |=> ((berr_a_q & $past(host_wdata)) == '0));
  // R1
  ptr_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ptr |=> (ptr_q == $past(host_wdata)));
  // R8
  pwr_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_q & SET_PWR) == SET_PWR);
  // R11
  unlisted_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && ptr_q == 32'h14) |=> $stable(eaddr_q));
endmodule

// File: tb/sim_sdcfg_top.sv
module sim_sdcfg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, we = 1'b0, port = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd0, rd1, tmg0, tmg1;
  logic [127:0] bank0;
  logic [63:0]  bank1;
  logic        en0, en1, irq0, irq1;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  sdcfg_top #(.NBANK(4)) u0 (.clk(clk), .rst(rst), .host_sel(sel), .host_we(we),
    .host_port(port), .host_wdata(wd), .host_rdata(rd0), .mem_en_o(en0),
    .bank_ctl_o(bank0), .tmg_o(tmg0), .irq_o(irq0));
  sdcfg_top #(.NBANK(2)) u1 (.clk(clk), .rst(rst), .host_sel(sel), .host_we(we),
    .host_port(port), .host_wdata(wd), .host_rdata(rd1), .mem_en_o(en1),
    .bank_ctl_o(bank1), .tmg_o(tmg1), .irq_o(irq1));

  typedef struct packed {
    logic [31:0] off;
    logic [31:0] wv;
    logic [31:0] ev;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{32'h10, 32'h12345678, 32'h12345678, 8'd3},  // R3 error address
    '{32'h30, 32'hFFFFFFFF, 32'h3FF80000, 8'd7},  // R7 refresh
    '{32'h34, 32'hFFFFFFFF, 32'hFFC00000, 8'd8},  // R8 power timer
    '{32'h34, 32'h00000000, 32'h07C00000, 8'd8},
    '{32'h40, 32'hFFFFFFFF, 32'hFFDEE001, 8'd9},  // R9 banks
    '{32'h44, 32'h12345678, 32'h12144000, 8'd9},
    '{32'h48, 32'hA5A5A5A5, 32'hA584A001, 8'd9},
    '{32'h4C, 32'hFFFFFFFF, 32'hFFDEE001, 8'd9},
    '{32'h94, 32'hFFFFFFFF, 32'h00F00000, 8'd7},  // R7 ECC config
    '{32'h80, 32'h12345678, 32'hFFFFFFFF, 8'd7},  // R7 timing reads ones
    '{32'h24, 32'hFFFFFFFF, 32'h00000000, 8'd6},  // R6 status
    '{32'h5C, 32'h00000001, 32'hFFFFFFFF, 8'd11}  // R11 unlisted
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic p, logic [31:0] v);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; port = p; wd = v;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_at(logic [31:0] off);
    wr(1'b0, off);
    port = 1'b1;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    port = 1'b0; #1;
    chk("R2 pointer", rd0, 32'h0);
    port = 1'b1; #1;
    chk("R2 berr at ptr 0", rd0, 32'h0);
    rd_at(32'h20); chk("R2 config", rd0, 32'h00800000);
    rd_at(32'h24); chk("R2 status", rd0, 32'h0);
    rd_at(32'h30); chk("R2 refresh", rd0, 32'h05F00000);
    rd_at(32'h34); chk("R2 power", rd0, 32'h07C00000);
    rd_at(32'h98); chk("R2 ecc err", rd0, 32'h0);
    chk("R2 timing out", tmg0, 32'h00854009);
    chk("R2 irq/en", {30'd0, irq0, en0}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      wr(1'b0, TBL[i].off);
      wr(1'b1, TBL[i].wv);
      port = 1'b1; #1;
      chk($sformatf("R%0d table row %0d", TBL[i].req, i), rd0, TBL[i].ev);
    end

    // R7 timing export
    chk("R7 timing out", tmg0, 32'h00044018);
    // R9 export, both bank counts
    chk("R9 bank0 out", bank0[31:0],   32'hFFDEE001);
    chk("R9 bank1 out", bank0[63:32],  32'h12144000);
    chk("R9 bank2 out", bank0[95:64],  32'hA584A001);
    chk("R9 bank3 out", bank0[127:96], 32'hFFDEE001);
    chk("R9 two-bank out hi", bank1[63:32], 32'h12144000);
    rd_at(32'h48);
    chk("R9 bank2 read", rd0, 32'hA584A001);
    chk("R11 bank2 absent", rd1, 32'hFFFFFFFF);

    // R1 pointer read-back
    wr(1'b0, 32'h0000ABCD);
    port = 1'b0; #1;
    chk("R1 pointer readback", rd0, 32'h0000ABCD);

    // R3 write-one-to-clear keeps zero
    rd_at(32'h08); wr(1'b1, 32'hFFFFFFFF); port = 1'b1; #1;
    chk("R3 berr b", rd0, 32'h0);

    // R11 write to unlisted 0x14 leaves error address alone
    wr(1'b0, 32'h14); wr(1'b1, 32'h0);
    rd_at(32'h10);
    chk("R11 unlisted write ignored", rd0, 32'h12345678);

    // R4 / R5 configuration edges
    wr(1'b0, 32'h20); wr(1'b1, 32'hFFFFFFFF);
    port = 1'b1; #1;
    chk("R4 config mask", rd0, 32'hFFE00000);
    chk("R4 enable out", {31'd0, en0}, 32'h1);
    rd_at(32'h24); chk("R5 status after rise", rd0, 32'h40000000);
    wr(1'b0, 32'h20); wr(1'b1, 32'h0);
    chk("R4 enable off", {31'd0, en0}, 32'h0);
    rd_at(32'h24); chk("R4 R5 status after fall", rd0, 32'h80000000);
    wr(1'b0, 32'h20); wr(1'b1, 32'h80000000);
    rd_at(32'h24); chk("R4 status after re-enable", rd0, 32'h0);
    wr(1'b0, 32'h20); wr(1'b1, 32'h0);
    wr(1'b0, 32'h24); wr(1'b1, 32'h0);
    port = 1'b1; #1;
    chk("R6 status write ignored", rd0, 32'h80000000);

    // R10 ECC error word and interrupt
    wr(1'b0, 32'h98); wr(1'b1, 32'h000F0FFF);
    port = 1'b1; #1;
    chk("R10 masked to zero", rd0, 32'h0);
    chk("R10 irq stays low", {31'd0, irq0}, 32'h0);
    wr(1'b1, 32'hFFFFFFFF); port = 1'b1; #1;
    chk("R10 ecc mask", rd0, 32'hFFF0F000);
    chk("R10 irq set", {31'd0, irq0}, 32'h1);
    wr(1'b1, 32'h00001000);
    chk("R10 irq held", {31'd0, irq0}, 32'h1);
    wr(1'b1, 32'h0);
    chk("R10 irq clear", {31'd0, irq0}, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule